// File: doc/BRIEF.md
# Three-Bit Serial Combination Lock

This block guards a door with a three-bit combination that the user enters one bit at a time. The user resets the lock and then performs three entries. For each entry the user sets the key switch to the wanted bit and presses the ENTER button. The lock compares each entered bit with the matching bit of a stored combination. It reveals the outcome only when the third entry is made: UNLOCK if every bit matched, ERROR otherwise. Because the verdict is held back, the timing of the lock's reaction gives no hint about which bit was wrong.

The stored combination sits in a small register with a plain write port, so it is not hardwired into the logic. A reset does not clear it. A rising-edge detector on ENTER turns each press into a single one-cycle pulse.

The controller has seven named states. On the good path, `ST_ARM0`, `ST_ARM1` and `ST_ARM2` each wait for the entry of bit 0, 1 or 2. `ST_OPEN` asserts UNLOCK. After the first mismatch the controller leaves the good path for a parallel error path. There, `ST_MISS1` and `ST_MISS2` keep counting entries while showing nothing, and `ST_ALARM` asserts ERROR.

The transitions are:
- An ARM state with a matching press moves to the next ARM state, or to `ST_OPEN` from `ST_ARM2`.
- An ARM state with a mismatching press moves to `ST_MISS1`, `ST_MISS2` or `ST_ALARM`.
- Any press in a MISS state moves one step along the error path.
- `ST_OPEN` and `ST_ALARM` ignore presses.
- Reset from any state returns to `ST_ARM0`.

Top module: `serial_keylock`

## Requirements
- R1: While and right after reset, `unlock` and `error` are both 0 and the lock waits for the first entry.
- R2: Each rising edge of `enter` counts as exactly one entry, however long `enter` stays high.
- R3: The first entry is compared with stored bit `code[0]`, the second with `code[1]` and the third with `code[2]`. The key value is taken in the cycle the press is seen.
- R4: If all three entries match, `unlock` goes to 1 one clock edge after the third press is sampled. It stays 1 until reset, and later presses are ignored.
- R5: If any entry mismatches, `error` goes to 1 only after the third press, even when the first bit was wrong. It stays 1 until reset, and later presses are ignored.
- R6: `unlock` and `error` are never both 1. Both are 0 after zero, one or two entries.
- R7: A cycle with `code_we`=1 loads `code_wdata` into the combination register. The value is kept across resets.
- R8: Reset returns the lock to the first-entry state from any state. If `enter` is held high while reset is released, that press is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the controller |
| enter | input | 1 | ENTER button level; a rising edge is one entry |
| key_bit | input | 1 | Key switch value for the current entry |
| code_we | input | 1 | Write enable of the combination register |
| code_wdata | input | 3 | New combination; bit i is checked at entry i+1 |
| unlock | output | 1 | Combination accepted |
| error | output | 1 | Combination rejected |

## Verification
Several properties are checked on every cycle by the assertions:
- The two outcome outputs are never both high.
- Each outcome is sticky once it is set.
- An outcome can only rise in the cycle after a press.
- The state stays put when there is no press.
- The press pulse never lasts two cycles.

The bench's scenarios cover what the assertions cannot. They compare each entered bit with the right stored position across all 64 combination and key pairs. They confirm that nothing is shown before the third press. They also cover a long held press, reset in the middle of an entry, a button held through reset, and a combination that survives reset.

// File: rtl/keylock_pkg.sv
package keylock_pkg;
    localparam int unsigned CODE_W = 3;
    localparam int unsigned IDX_W  = $clog2(CODE_W);

    typedef enum logic [2:0] {
        ST_ARM0,
        ST_ARM1,
        ST_ARM2,
        ST_MISS1,
        ST_MISS2,
        ST_OPEN,
        ST_ALARM
    } lock_state_t;
endpackage

// File: rtl/press_detect.sv
module press_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic enter,
    output logic press
);
    logic enter_q;

    // Reset value 1: a button held through reset must be released first (R8)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) enter_q <= 1'b1;
        else        enter_q <= enter;
    end

    assign press = enter && !enter_q;

    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        press |=> !press);
endmodule

// File: rtl/code_store.sv
module code_store #(
    parameter int unsigned W = 3
) (
    input  logic         clk,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] code
);
    logic [W-1:0] code_q = '0;

    // Not reset on purpose: the combination survives a user reset (R7)
    always_ff @(posedge clk) begin
        if (we) code_q <= wdata;
    end

    assign code = code_q;
endmodule

// File: rtl/keylock_fsm.sv
module keylock_fsm
    import keylock_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              press,
    input  logic              key_bit,
    input  logic [CODE_W-1:0] code,
    output logic              unlock,
    output logic              error
);
    lock_state_t state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_ARM0;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_ARM0:  if (press) state_nx = (key_bit == code[0]) ? ST_ARM1 : ST_MISS1;
            ST_ARM1:  if (press) state_nx = (key_bit == code[1]) ? ST_ARM2 : ST_MISS2;
            ST_ARM2:  if (press) state_nx = (key_bit == code[2]) ? ST_OPEN : ST_ALARM;
            ST_MISS1: if (press) state_nx = ST_MISS2;
            ST_MISS2: if (press) state_nx = ST_ALARM;
            ST_OPEN:  state_nx = ST_OPEN;
            ST_ALARM: state_nx = ST_ALARM;
            default:  state_nx = ST_ARM0;
        endcase
    end

    always_comb begin
        unlock = 1'b0;
        error  = 1'b0;
        unique case (state)
            ST_OPEN:  unlock = 1'b1;
            ST_ALARM: error  = 1'b1;
            default: begin
                unlock = 1'b0;
                error  = 1'b0;
            end
        endcase
    end

    a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(unlock && error));
    a_r4_unlock_holds: assert property (@(posedge clk) disable iff (!rst_n)
        unlock |=> unlock);
    a_r5_error_holds: assert property (@(posedge clk) disable iff (!rst_n)
        error |=> error);
    a_r6_outcome_after_press: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(unlock) || $rose(error)) |-> $past(press));
    a_r2_idle_no_move: assert property (@(posedge clk) disable iff (!rst_n)
        !press |=> $stable(state));
endmodule

// File: rtl/serial_keylock.sv
module serial_keylock
    import keylock_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enter,
    input  logic              key_bit,
    input  logic              code_we,
    input  logic [CODE_W-1:0] code_wdata,
    output logic              unlock,
    output logic              error
);
    logic              press;
    logic [CODE_W-1:0] code;

    press_detect u_press (
        .clk   (clk),
        .rst_n (rst_n),
        .enter (enter),
        .press (press)
    );

    code_store #(.W(CODE_W)) u_code (
        .clk   (clk),
        .we    (code_we),
        .wdata (code_wdata),
        .code  (code)
    );

    keylock_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .press   (press),
        .key_bit (key_bit),
        .code    (code),
        .unlock  (unlock),
        .error   (error)
    );
endmodule

// File: tb/sim_serial_keylock.sv
`timescale 1ns/1ps
module sim_serial_keylock;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enter = 1'b0;
    logic       key_bit = 1'b0;
    logic       code_we = 1'b0;
    logic [2:0] code_wdata = 3'b000;
    logic       unlock, error;
    int         n_chk = 0;
    int         n_bad = 0;

    always #5 clk = ~clk;

    serial_keylock u0 (
        .clk(clk), .rst_n(rst_n), .enter(enter), .key_bit(key_bit),
        .code_we(code_we), .code_wdata(code_wdata),
        .unlock(unlock), .error(error)
    );

    task automatic chk(input string req, input logic [1:0] exp);
        n_chk++;
        if ({unlock, error} !== exp) begin
            n_bad++;
            $display("FAIL %s: {unlock,error} actual=%b expected=%b", req, {unlock, error}, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk) rst_n = 1'b1;
    endtask

    task automatic load_code(input logic [2:0] c);
        @(negedge clk) begin code_we = 1'b1; code_wdata = c; end
        @(negedge clk) code_we = 1'b0;
    endtask

    // enter high for one cycle, low for one; sampled at the negedge after release
    task automatic press_bit(input logic b);
        @(negedge clk) begin key_bit = b; enter = 1'b1; end
        @(negedge clk) enter = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset_state();
        rst_n = 1'b0;
        @(negedge clk) chk("R1 during reset", 2'b00);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk) chk("R1 after reset", 2'b00);
    endtask

    task automatic t_exhaustive();
        for (int c = 0; c < 8; c++) begin
            load_code(c[2:0]);
            for (int k = 0; k < 8; k++) begin
                do_reset();
                press_bit(k[0]);
                chk("R6 low after entry 1", 2'b00);
                press_bit(k[1]);
                chk("R6 low after entry 2", 2'b00);
                press_bit(k[2]);
                if (k == c) chk("R3 R4 match unlocks", 2'b10);
                else        chk("R3 R5 mismatch errors", 2'b01);
                press_bit(~k[0]);
                if (k == c) chk("R4 unlock sticky", 2'b10);
                else        chk("R5 error sticky", 2'b01);
            end
        end
    endtask

    task automatic t_long_hold();
        load_code(3'b101);
        do_reset();
        @(negedge clk) begin key_bit = 1'b1; enter = 1'b1; end
        repeat (6) @(negedge clk);
        enter = 1'b0;
        @(negedge clk) chk("R2 held press counts once", 2'b00);
        press_bit(1'b0);
        chk("R2 second entry only", 2'b00);
        press_bit(1'b1);
        chk("R2 third entry unlocks", 2'b10);
    endtask

    task automatic t_first_bit_wrong();
        load_code(3'b010);
        do_reset();
        press_bit(1'b1);
        chk("R5 no early error after entry 1", 2'b00);
        press_bit(1'b1);
        chk("R5 no early error after entry 2", 2'b00);
        press_bit(1'b0);
        chk("R5 error after entry 3", 2'b01);
    endtask

    task automatic t_reset_midway();
        load_code(3'b011);
        do_reset();
        press_bit(1'b0);
        press_bit(1'b0);
        do_reset();
        chk("R8 reset mid entry clears", 2'b00);
        press_bit(1'b1);
        press_bit(1'b1);
        press_bit(1'b0);
        chk("R8 fresh entry after reset", 2'b10);
        do_reset();
        chk("R8 reset leaves open state", 2'b00);
    endtask

    task automatic t_held_through_reset();
        load_code(3'b000);
        @(negedge clk) begin key_bit = 1'b1; enter = 1'b1; rst_n = 1'b0; end
        @(negedge clk) rst_n = 1'b1;
        repeat (3) @(negedge clk);
        enter = 1'b0;
        @(negedge clk);
        press_bit(1'b0);
        press_bit(1'b0);
        chk("R8 held press not counted", 2'b00);
        press_bit(1'b0);
        chk("R8 three real entries unlock", 2'b10);
    endtask

    task automatic t_code_retained();
        load_code(3'b110);
        do_reset();
        do_reset();
        press_bit(1'b0);
        press_bit(1'b1);
        press_bit(1'b1);
        chk("R7 code kept across reset", 2'b10);
        load_code(3'b001);
        do_reset();
        press_bit(1'b1);
        press_bit(1'b0);
        press_bit(1'b0);
        chk("R7 new code loaded", 2'b10);
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        n_chk++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset_state();
        t_exhaustive();
        t_long_hold();
        t_first_bit_wrong();
        t_reset_midway();
        t_held_through_reset();
        t_code_retained();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule